// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

A bank of seven 32-bit registers that collects interrupt events from up to `NUM_SRC` hardware sources and reduces them to a single interrupt line. Source *n* owns bit *n* in every register of the bank. A hardware event pulse latches into a sticky cause bit. A mask bit of 1 blocks that source. The interrupt output is high whenever an unmasked cause bit is pending.

Software selects the clearing rule for each bit at run time. A bit is either cleared by writing 1 to it, or cleared as a side effect of reading it. The mask can be written whole, or changed bit by bit through separate set and clear aliases, so no read-modify-write sequence is needed. The cause register also has a write-only set alias, which lets software raise an interrupt by itself. Access goes through a simple synchronous bus with a write strobe and a read strobe. Read data is registered.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1, every clear-mode bit is 0 and `irq_o` is low.
- R2: Registers sit at byte addresses 0x00 clear-mode, 0x04 cause, 0x08 masked cause, 0x0C cause-set, 0x10 mask, 0x14 mask-set and 0x18 mask-clear. An address that is not word aligned, or any other address, reads as 0, and a write to it changes nothing.
- R3: `rdata` carries the addressed value in the cycle after a cycle with `rd_en` high, and is 0 in the cycle after a cycle with `rd_en` low. The cause-set, mask-set and mask-clear addresses read as 0.
- R4: A high `evt_i` bit sets its cause bit at the next clock edge. When an event and any clear hit the same bit in the same cycle, the bit ends up set.
- R5: For a bit whose clear-mode bit is 0, writing 1 to it at the cause or masked-cause address clears the cause bit. Writing 0 leaves it unchanged, and reads do not clear it.
- R6: For a bit whose clear-mode bit is 1, a read of the cause address clears it. A read of the masked-cause address clears it only if its mask bit is 0. Writes to either address do not clear it.
- R7: The masked-cause address reads cause AND NOT mask, using the values from before the read edge.
- R8: Writing 1 to a bit of the cause-set address sets that cause bit. Writing 0 has no effect.
- R9: The mask address is read/write. Writing 1 to a mask-set bit sets that mask bit, and writing 1 to a mask-clear bit clears it. Writing 0 to either alias has no effect.
- R10: `irq_o` is high exactly when some bit has cause 1 and mask 0. It follows the register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Hardware event pulses, one per source |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Cause, mask and clear-mode state all change at the clock edge that samples a strobe or an event. `irq_o` reflects the new state in the same cycle, so it is due one edge after the stimulus. Read data is also due one edge after the read strobe, and it carries the value from before that edge. The bench drives every input on the falling edge and compares on the next falling edge. There, a reference model updated once per driven cycle supplies both the expected read value and the expected interrupt level. Random traffic over all byte addresses, including misaligned and unmapped ones, is mixed with directed cases: an event colliding with a clear, reads that clear through the masked view, and the set/clear aliases.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   typedef enum logic [2:0] {
      SEL_MODE   = 3'd0,
      SEL_CAUSE  = 3'd1,
      SEL_MCAUSE = 3'd2,
      SEL_CSET   = 3'd3,
      SEL_MASK   = 3'd4,
      SEL_MSET   = 3'd5,
      SEL_MCLR   = 3'd6,
      SEL_NONE   = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic wr_mode;
      logic wr_cause;
      logic wr_mcause;
      logic wr_cset;
      logic wr_mask;
      logic wr_mset;
      logic wr_mclr;
      logic rd_cause;
      logic rd_mcause;
   } bank_strb_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output bank_strb_t        strb
);

   logic hi_zero;

   generate
      if (ADDR_W > 5) begin : g_wide
         assign hi_zero = (addr[ADDR_W-1:5] == '0);
      end else begin : g_narrow
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      if (hi_zero && (addr[1:0] == 2'b00))
         sel = reg_sel_e'(addr[4:2]);
      else
         sel = SEL_NONE;

      strb           = '0;
      strb.wr_mode   = wr_en && (sel == SEL_MODE);
      strb.wr_cause  = wr_en && (sel == SEL_CAUSE);
      strb.wr_mcause = wr_en && (sel == SEL_MCAUSE);
      strb.wr_cset   = wr_en && (sel == SEL_CSET);
      strb.wr_mask   = wr_en && (sel == SEL_MASK);
      strb.wr_mset   = wr_en && (sel == SEL_MSET);
      strb.wr_mclr   = wr_en && (sel == SEL_MCLR);
      strb.rd_cause  = rd_en && (sel == SEL_CAUSE);
      strb.rd_mcause = rd_en && (sel == SEL_MCAUSE);
   end

endmodule

// File: rtl/irq_mode_mask_reg.sv
module irq_mode_mask_reg
   import irq_bank_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  bank_strb_t         strb,
   input  logic [NUM_SRC-1:0] wval,
   output logic [NUM_SRC-1:0] mode_q,
   output logic [NUM_SRC-1:0] mask_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         mask_q <= '1;
      end else begin
         if (strb.wr_mode)
            mode_q <= wval;
         if (strb.wr_mask)
            mask_q <= wval;
         else if (strb.wr_mset)
            mask_q <= mask_q | wval;
         else if (strb.wr_mclr)
            mask_q <= mask_q & ~wval;
      end
   end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
   import irq_bank_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  bank_strb_t         strb,
   input  logic [NUM_SRC-1:0] wval,
   input  logic [NUM_SRC-1:0] mode_q,
   input  logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] cause_q
);

   logic wr_clr_any;
   assign wr_clr_any = strb.wr_cause | strb.wr_mcause;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic set_b, w1c_b, cor_b;
      assign set_b = evt_i[i] | (strb.wr_cset & wval[i]);
      assign w1c_b = wr_clr_any & wval[i] & ~mode_q[i];
      assign cor_b = mode_q[i] & (strb.rd_cause | (strb.rd_mcause & ~mask_q[i]));

      always_ff @(posedge clk) begin
         if (!rst_n)
            cause_q[i] <= 1'b0;
         else if (set_b)
            cause_q[i] <= 1'b1;
         else if (w1c_b | cor_b)
            cause_q[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
   import irq_bank_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  reg_sel_e           sel,
   input  logic [NUM_SRC-1:0] mode_q,
   input  logic [NUM_SRC-1:0] cause_q,
   input  logic [NUM_SRC-1:0] masked_w,
   input  logic [NUM_SRC-1:0] mask_q,
   output logic [DATA_W-1:0]  rdata
);

   logic [NUM_SRC-1:0] pick;
   logic [DATA_W-1:0]  pick_ext;

   always_comb begin
      unique case (sel)
         SEL_MODE:   pick = mode_q;
         SEL_CAUSE:  pick = cause_q;
         SEL_MCAUSE: pick = masked_w;
         SEL_MASK:   pick = mask_q;
         default:    pick = '0;
      endcase
   end

   generate
      if (DATA_W > NUM_SRC) begin : g_pad
         assign pick_ext = {{(DATA_W-NUM_SRC){1'b0}}, pick};
      end else begin : g_full
         assign pick_ext = pick;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= pick_ext;
      else
         rdata <= '0;
   end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
   import irq_bank_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               irq_o
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie between 1 and DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must be at least 5 to reach seven words");
      end
   endgenerate

   reg_sel_e           sel;
   bank_strb_t         strb;
   logic [NUM_SRC-1:0] wval;
   logic [NUM_SRC-1:0] mode_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] cause_q;
   logic [NUM_SRC-1:0] masked_w;

   assign wval     = wdata[NUM_SRC-1:0];
   assign masked_w = cause_q & ~mask_q;
   assign irq_o    = |masked_w;

   irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .sel   (sel),
      .strb  (strb)
   );

   irq_mode_mask_reg #(.NUM_SRC(NUM_SRC)) u_mm (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb   (strb),
      .wval   (wval),
      .mode_q (mode_q),
      .mask_q (mask_q)
   );

   irq_cause_reg #(.NUM_SRC(NUM_SRC)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i),
      .strb    (strb),
      .wval    (wval),
      .mode_q  (mode_q),
      .mask_q  (mask_q),
      .cause_q (cause_q)
   );

   irq_read_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .sel      (sel),
      .mode_q   (mode_q),
      .cause_q  (cause_q),
      .masked_w (masked_w),
      .mask_q   (mask_q),
      .rdata    (rdata)
   );

endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [DATA_W-1:0]  wdata,
   input logic [DATA_W-1:0]  rdata,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] cause_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] mode_q
);

   logic at_cset, at_mset, at_mclr, at_cause;
   assign at_cause = (addr == ADDR_W'(8'h04));
   assign at_cset  = (addr == ADDR_W'(8'h0C));
   assign at_mset  = (addr == ADDR_W'(8'h14));
   assign at_mclr  = (addr == ADDR_W'(8'h18));

   // R4
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

   // R8
   cset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_cset) |=>
         ((cause_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

   // R9
   mset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_mset) |=>
         ((mask_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

   // R9
   mclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_mclr) |=> ((mask_q & $past(wdata[NUM_SRC-1:0])) == '0));

   // R3
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));

   // R3
   wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (at_cset || at_mset || at_mclr)) |=> (rdata == '0));

   // R5
   w1c_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && at_cause && (mode_q == '0)) |=>
         ((cause_q & $past(cause_q)) == $past(cause_q)));

   // R10
   irq_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq_o);

   // R10
   irq_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q == '0) |-> !irq_o);

endmodule

bind irq_cause_bank irq_cause_bank_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_i   (evt_i),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .irq_o   (irq_o),
   .cause_q (cause_q),
   .mask_q  (mask_q),
   .mode_q  (mode_q)
);

// File: tb/irq_cause_bank_test.sv
`timescale 1ns/1ps
module irq_cause_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_i = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   logic [31:0] m_cause, m_mask, m_mode;

   always #10 clk = ~clk;

   irq_cause_bank uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
         summary();
         $finish;
      end
   end

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // word index of a byte address, 7 when unmapped or misaligned (R2)
   function automatic int widx(input logic [4:0] a);
      if (a[1:0] != 2'b00) return 7;
      return int'(a[4:2]);
   endfunction

   function automatic logic [31:0] rd_val(input logic [4:0] a);
      case (widx(a))
         0: return m_mode;
         1: return m_cause;
         2: return m_cause & ~m_mask;
         4: return m_mask;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [4:0] a);
      case (widx(a))
         0: return "R2";
         1: return "R6";
         2: return "R7";
         4: return "R9";
         default: return "R3";
      endcase
   endfunction

   // one bus cycle: drive at falling edge, check at next falling edge
   task automatic step(input logic w, input logic r, input logic [4:0] a,
                       input logic [31:0] wd, input logic [31:0] ev, input string tag);
      logic [31:0] exp_rd, set_v, clr_v;
      int k;
      k = widx(a);
      exp_rd = r ? rd_val(a) : 32'h0;
      set_v  = ev | ((w && k == 3) ? wd : 32'h0);
      clr_v  = '0;
      if (w && (k == 1 || k == 2)) clr_v |= wd & ~m_mode;
      if (r && k == 1) clr_v |= m_mode;
      if (r && k == 2) clr_v |= m_mode & ~m_mask;
      m_cause = (m_cause & ~clr_v) | set_v;
      if (w && k == 0) m_mode = wd;
      if (w && k == 4) m_mask = wd;
      if (w && k == 5) m_mask = m_mask | wd;
      if (w && k == 6) m_mask = m_mask & ~wd;
      wr_en = w; rd_en = r; addr = a; wdata = wd; evt_i = ev;
      @(negedge clk);
      wr_en = 0; rd_en = 0; evt_i = '0;
      cmp(tag == "" ? (r ? rd_tag(a) : "R3") : tag, rdata, exp_rd);
      cmp("R10", {31'h0, irq_o}, {31'h0, |(m_cause & ~m_mask)});
   endtask

   initial begin
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'd12345);
      m_cause = '0; m_mask = '1; m_mode = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      cmp("R1", {31'h0, irq_o}, 32'h0);
      step(0, 1, 5'h00, 0, 0, "R1");
      step(0, 1, 5'h10, 0, 0, "R1");
      step(0, 1, 5'h04, 0, 0, "R1");

      // R4: event sets while masked, no irq
      step(0, 0, 5'h00, 0, 32'h0000_0005, "R4");
      step(0, 1, 5'h04, 0, 0, "R4");
      // R9: mask-clear alias unmasks bit 0, irq rises
      step(1, 0, 5'h18, 32'h0000_0001, 0, "R9");
      step(0, 1, 5'h10, 0, 0, "R9");
      // R7: masked view
      step(0, 1, 5'h08, 0, 0, "R7");
      // R5: write 0 has no effect, write 1 clears, read does not clear
      step(1, 0, 5'h04, 32'h0000_0000, 0, "R5");
      step(0, 1, 5'h04, 0, 0, "R5");
      step(1, 0, 5'h08, 32'h0000_0001, 0, "R5");
      step(0, 1, 5'h04, 0, 0, "R5");
      // R4: event collides with write-1-to-clear, event wins
      step(1, 0, 5'h04, 32'h0000_0004, 32'h0000_0004, "R4");
      step(0, 1, 5'h04, 0, 0, "R4");
      // R8: cause-set alias
      step(1, 0, 5'h0C, 32'h0000_0300, 0, "R8");
      step(0, 1, 5'h04, 0, 0, "R8");
      // R6: clear-on-read mode on bits 8,9; bit 9 masked, bit 8 unmasked
      step(1, 0, 5'h00, 32'h0000_0300, 0, "R6");
      step(1, 0, 5'h18, 32'h0000_0100, 0, "R9");
      step(1, 0, 5'h04, 32'h0000_0300, 0, "R6");
      step(0, 1, 5'h08, 0, 0, "R6");
      step(0, 1, 5'h04, 0, 0, "R6");
      step(0, 1, 5'h04, 0, 0, "R6");
      // R6: read collides with event on a clear-on-read bit
      step(0, 1, 5'h04, 0, 32'h0000_0100, "R6");
      step(0, 1, 5'h04, 0, 0, "R6");
      // R2: misaligned and unmapped writes ignored
      step(1, 0, 5'h11, 32'h0, 0, "R2");
      step(1, 0, 5'h1C, 32'h0, 0, "R2");
      step(0, 1, 5'h10, 0, 0, "R2");
      step(0, 1, 5'h1C, 0, 0, "R2");
      // R3: write-only aliases read zero
      step(0, 1, 5'h0C, 0, 0, "R3");
      step(0, 1, 5'h14, 0, 0, "R3");
      // R9: full mask write and set alias
      step(1, 0, 5'h10, 32'h0F0F_0000, 0, "R9");
      step(1, 0, 5'h14, 32'h0000_00F0, 0, "R9");
      step(0, 1, 5'h10, 0, 0, "R9");

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         logic w, r;
         logic [4:0] a;
         logic [31:0] wd, ev;
         int pick;
         pick = $urandom_range(0, 9);
         w  = (pick < 4);
         r  = (pick >= 3 && pick < 8);
         a  = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'({$urandom_range(0, 7), 2'b00});
         wd = $urandom & $urandom;
         ev = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
         step(w, r, a, wd, ev, "");
      end

      done = 1;
      summary();
      $finish;
   end

endmodule